// File: doc/BRIEF.md
# Converter-Side Serial Frame Shifter

This block is the digital half of a sampling converter's serial output port. It covers the mode in which the host's serial clock also paces the conversion. When chip select goes low, a frame begins. The output enable turns on and the hold flag is raised, which is the sampling instant. The 12-bit result on the parallel input is captured at that moment. The frame on the serial data pin is four zero bits followed by the captured result, most significant bit first.

The first zero is on the pin as soon as chip select falls is seen. After that, each falling serial clock edge presents the next bit. Hold releases on the 14th falling edge, and the output enable turns off on the 16th. Once the frame is over, further falling edges change nothing. A rise of chip select at any point turns the output off and drops hold at once, which aborts the frame.

Chip select and the serial clock are sampled by the system clock `clk_i`. They are assumed to be already synchronous to it and much slower than it. Every output responds in the cycle after the input change is sampled. The serial clock idles high.

Top module: `serial_frame_shifter`

## Requirements
- R1: After reset, and whenever the output enable is low, `sdo_o`, `sdo_oe_o` and `hold_o` are all 0.
- R2: One cycle after chip select is sampled falling, `sdo_oe_o`=1, `hold_o`=1 and `sdo_o`=0. This is the first leading zero.
- R3: The frame word is {4'b0000, sample[11:0]}, numbered bit 15 down to bit 0. After the k-th falling serial clock edge of the frame (k=1..15), `sdo_o` shows word bit 15-k. So edge 1 shows the second zero, edge 4 shows sample bit 11, and edge 15 shows sample bit 0.
- R4: The output enable stays 1 through falling edges 1 to 15. It drops to 0 one cycle after the 16th falling edge.
- R5: `hold_o` stays 1 through falling edges 1 to 13. It drops to 0 one cycle after the 14th falling edge.
- R6: If chip select rises before the 16th falling edge, `sdo_oe_o` and `hold_o` are 0 in the next cycle.
- R7: The sample is captured when chip select falls. Changes on `sample_i` during the frame do not change the bits shifted out.
- R8: Falling edges after the 16th, while chip select stays low, leave `sdo_oe_o`, `hold_o` and `sdo_o` at 0.
- R9: `sdo_o` changes only on a chip-select fall or a serial clock fall. A reader that samples on rising edges therefore gets the second zero on rising edge 1 and sample bit 0 on rising edge 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| sample_i | input | 12 | Parallel conversion result from the converter stub |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable (0 means high impedance) |
| hold_o | output | 1 | Track/hold control: 1 means hold, 0 means track |

## Verification
Full frames are run with the all-zeros, all-ones, alternating, single-bit and walking-one samples. A shift off by one position, a wrong bit order or a lost leading zero shows up as a mismatch on at least one of these patterns. The input sample is inverted right after chip select falls, which separates a captured word from one read live. Frames are aborted after every edge count from 0 to 15, which tells an abort path apart from the normal hold and enable release points. Extra falling edges after the 16th test saturation. Each bit is read after both the falling and the rising edge, which confirms that reading on either edge gives the same bit.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ssf_edge_det.sv
module ssf_edge_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic d_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= IDLE;
    else         d_q <= d_i;
  end
  assign fall_o = d_q & ~d_i;
endmodule

// File: rtl/ssf_edge_counter.sv
module ssf_edge_counter #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned CNT_W = ssf_pkg::cnt_width(LIMIT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_o <= '0;
    else if (clear_i)                            cnt_o <= '0;
    else if (step_i && cnt_o != CNT_W'(LIMIT))   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ssf_shift_reg.sv
module ssf_shift_reg #(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned LEAD_ZEROS = 4,
  localparam int unsigned WORD_W    = DATA_W + LEAD_ZEROS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {{LEAD_ZEROS{1'b0}}, data_i};
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end
  assign msb_o = sr_q[WORD_W-1];
endmodule

// File: rtl/serial_frame_shifter.sv
module serial_frame_shifter #(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned LEAD_ZEROS = 4,
  parameter int unsigned HOLD_EDGE  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              hold_o
);
  localparam int unsigned FRAME_LEN = DATA_W + LEAD_ZEROS;
  localparam int unsigned CNT_W     = ssf_pkg::cnt_width(FRAME_LEN);

  logic cs_fall, sclk_fall, start, adv, msb;
  logic active_q, hold_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  ssf_edge_det #(.IDLE(1'b1)) i_cs_edge (
    .clk_i, .rst_ni, .d_i(cs_ni), .fall_o(cs_fall));
  ssf_edge_det #(.IDLE(1'b1)) i_sclk_edge (
    .clk_i, .rst_ni, .d_i(sclk_i), .fall_o(sclk_fall));

  assign start   = cs_fall;
  assign adv     = sclk_fall & active_q & ~cs_ni & ~start;
  assign cnt_nxt = cnt_q + 1'b1;

  ssf_edge_counter #(.LIMIT(FRAME_LEN), .CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .clear_i(start), .step_i(adv), .cnt_o(cnt_q));

  ssf_shift_reg #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) i_sr (
    .clk_i, .rst_ni, .load_i(start), .shift_i(adv), .data_i(sample_i), .msb_o(msb));

  // chip select high overrides everything: abort or idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (cs_ni) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      hold_q   <= 1'b1;
    end else if (adv) begin
      if (cnt_nxt == CNT_W'(HOLD_EDGE)) hold_q   <= 1'b0;
      if (cnt_nxt == CNT_W'(FRAME_LEN)) active_q <= 1'b0;
    end
  end

  assign sdo_oe_o = active_q;
  assign sdo_o    = active_q & msb;
  assign hold_o   = hold_q;
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned FRAME_LEN = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             sclk_i,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             hold_o,
  input logic [CNT_W-1:0] cnt_i
);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_ni) |=> (sdo_oe_o && hold_o && !sdo_o));

  p_cs_high_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!sdo_oe_o && !hold_o));

  p_hold_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> sdo_oe_o);

  p_quiet_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  p_sdo_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$fell(cs_ni) && sclk_i) |=> $stable(sdo_o));

  p_saturated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(FRAME_LEN) && !$fell(cs_ni)) |=> !sdo_oe_o);
endmodule

bind serial_frame_shifter ssf_checker #(.CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) i_ssf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .hold_o(hold_o), .cnt_i(cnt_q));

// File: tb/test_serial_frame_shifter.sv
`timescale 1ns/1ps
module test_serial_frame_shifter;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
  logic [11:0] sample = '0;
  logic sdo, sdo_oe, hold;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_frame_shifter i_serial_frame_shifter (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sample_i(sample),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_o(hold));

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic c, input logic s);
    @(negedge clk); cs_n = c; sclk = s;
    @(posedge clk); #1;
  endtask

  // n_fall: falling edges before chip select rises
  task automatic frame(input logic [11:0] smp, input int n_fall);
    logic [15:0] word;
    word = {4'b0000, smp};
    @(negedge clk); sample = smp;
    step(1'b0, 1'b1);
    chk("R2 oe", sdo_oe, 1'b1);
    chk("R2 hold", hold, 1'b1);
    chk("R2 first zero", sdo, 1'b0);
    sample = ~smp;  // R7: input changes after capture
    for (int k = 1; k <= n_fall; k++) begin
      step(1'b0, 1'b0);
      if (k <= 15) begin
        chk($sformatf("R3 R7 bit after fall %0d", k), sdo, word[15-k]);
        chk($sformatf("R4 oe after fall %0d", k), sdo_oe, 1'b1);
      end else begin
        chk($sformatf("R4 R8 oe after fall %0d", k), sdo_oe, 1'b0);
        chk($sformatf("R8 R1 sdo after fall %0d", k), sdo, 1'b0);
      end
      chk($sformatf("R5 hold after fall %0d", k), hold, (k < 14) ? 1'b1 : 1'b0);
      step(1'b0, 1'b1);
      if (k <= 15)
        chk($sformatf("R9 bit at rise %0d", k), sdo, word[15-k]);
    end
    step(1'b1, 1'b1);
    chk("R6 oe after cs rise", sdo_oe, 1'b0);
    chk("R6 hold after cs rise", hold, 1'b0);
    chk("R1 sdo idle", sdo, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe in reset", sdo_oe, 1'b0);
    chk("R1 hold in reset", hold, 1'b0);
    chk("R1 sdo in reset", sdo, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b1);
    chk("R1 oe after reset", sdo_oe, 1'b0);
    // full frames, varied data patterns
    frame(12'h000, 16);
    frame(12'hFFF, 16);
    frame(12'hAAA, 16);
    frame(12'h555, 16);
    frame(12'h801, 16);
    for (int b = 0; b < 12; b++) frame(12'(1 << b), 16);
    // extra edges past saturation
    frame(12'hC3A, 20);
    // aborts after every edge count
    for (int n = 0; n < 16; n++) frame(12'h9B6 ^ 12'(n * 37), n);
    // back-to-back full frame after aborts
    frame(12'h7E1, 16);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule